// File: doc/BRIEF.md
# Hashed Flow Activity Counter with Interval Reporting

The block keeps a running total of activity for each flow in an on-chip table. Each input carries a 32-bit flow ID and an increment. The increment can be a byte count, to measure bandwidth, or a fixed value such as one, to count events like new connections. A fixed XOR fold of the ID picks one table entry, and the entry holds the ID that owns it and a saturating count. Each update passes through three registered steps. The first reads the entry, the second adds the increment, and the third writes the result back. When a new input targets an entry that is still in flight, the newer in-flight value is forwarded to it. This keeps bursts of updates to one flow exact at one update per clock.

At the end of an observation interval a one-cycle pulse closes the interval. Input is held off while the pipeline drains. The table is then walked in ascending address order. For every entry whose count is above a programmable limit, the block emits the owning ID and its count, one slot per clock. Each entry is zeroed as it is visited. A done pulse marks the end of the walk, and input resumes for the next interval. After reset the same walk runs once without reporting, so the table starts empty.

Top module: `hhd_flow_counter`

## Requirements
- R1: The entry address is the XOR of ID bits [9:0], [19:10] and [29:20] with bits [31:30] zero-extended to 10 bits. Reports come out in ascending address order.
- R2: An update whose ID equals the stored owner adds its increment to the stored count.
- R3: Updates to the same flow on consecutive clocks, in a run of any length, all accumulate exactly.
- R4: Updates to the same flow separated by one or two other accepted updates accumulate exactly.
- R5: An update whose ID differs from the stored owner of its entry replaces the owner with the new ID, and the count restarts at the increment.
- R6: A count that would pass 2^32-1 stays at 2^32-1.
- R7: An update accepted in the same clock as the interval-end pulse belongs to the closing interval. in_ready is low in the clock after the pulse and stays low until the walk ends.
- R8: During the walk, rep_valid marks one entry per slot whose count is strictly greater than threshold, with rep_id and rep_count. An entry whose count equals threshold is not reported.
- R9: rep_done is a one-clock pulse in the clock after the last walk slot, and in_ready is high again by then.
- R10: After a report walk every entry is empty, so counts in the next interval start from zero.
- R11: An interval-end pulse that arrives while the block is draining or walking has no effect: no second walk follows.
- R12: After reset, rep_valid and rep_done are low and in_ready stays low during the clearing walk. No report is made for that walk, and in_ready then goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Update present |
| in_ready | output | 1 | Update accepted this clock when high together with in_valid |
| in_id | input | 32 | Flow ID |
| in_inc | input | 32 | Amount to add to the flow |
| interval_end | input | 1 | One-clock pulse that closes the interval |
| threshold | input | 32 | Report limit; counts strictly above it are reported |
| rep_valid | output | 1 | Report slot carries a flow over the limit |
| rep_id | output | 32 | Reported flow ID |
| rep_count | output | 32 | Reported flow count |
| rep_done | output | 1 | Pulse after the last walk slot |

## Verification
The main stream mixes several access patterns. One flow is hit on three consecutive clocks, which exercises forwarding from the modify step, including a chain. Other flows are hit with one or two unrelated updates in between, which separates the write-step forward from a plain table read. Two IDs that fold to the same entry show replacement rather than merging. A near-full count shows saturation, and one count equal to the limit marks the report boundary. A second interval then shows that the table was cleared, that an update sharing a clock with the closing pulse is included, and that a pulse during a walk is ignored.

// File: rtl/hhd_pkg.sv
package hhd_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_SCAN  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/hhd_hash.sv
module hhd_hash #(
  parameter int ID_W   = 32,
  parameter int ADDR_W = 10
) (
  input  logic [ID_W-1:0]   id,
  output logic [ADDR_W-1:0] addr
);
  localparam int NCHUNK = (ID_W + ADDR_W - 1) / ADDR_W;
  localparam int PAD_W  = NCHUNK * ADDR_W;

  logic [PAD_W-1:0]  id_pad;
  logic [ADDR_W-1:0] fold [NCHUNK+1];

  assign id_pad  = PAD_W'(id);
  assign fold[0] = '0;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_fold
    assign fold[g+1] = fold[g] ^ id_pad[g*ADDR_W +: ADDR_W];
  end

  assign addr = fold[NCHUNK];
endmodule

// File: rtl/hhd_table.sv
module hhd_table #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hhd_update.sv
module hhd_update #(
  parameter int ID_W   = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [ID_W-1:0]         in_id,
  input  logic [CNT_W-1:0]        in_inc,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [ID_W+CNT_W-1:0]   rd_data,
  output logic                    busy,
  output logic                    wr_en,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [ID_W+CNT_W-1:0]   wr_data
);
  localparam int ENT_W = ID_W + CNT_W;

  // read step registers
  logic              rd_vld_q;
  logic [ID_W-1:0]   rd_id_q;
  logic [CNT_W-1:0]  rd_inc_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [ENT_W-1:0]  rd_ent_q;
  // write step registers
  logic              wb_vld_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [ENT_W-1:0]  wb_ent_q;

  logic [ID_W-1:0]   cur_tag;
  logic [CNT_W-1:0]  cur_cnt;
  logic [CNT_W:0]    sum;
  logic [CNT_W-1:0]  mod_cnt;
  logic [ENT_W-1:0]  mod_ent;
  logic [ENT_W-1:0]  src_ent;

  // modify step: add or restart, saturating
  assign cur_tag = rd_ent_q[CNT_W +: ID_W];
  assign cur_cnt = rd_ent_q[CNT_W-1:0];
  assign sum     = {1'b0, cur_cnt} + {1'b0, rd_inc_q};

  always_comb begin
    if (cur_tag != rd_id_q)  mod_cnt = rd_inc_q;
    else if (sum[CNT_W])     mod_cnt = '1;
    else                     mod_cnt = sum[CNT_W-1:0];
  end
  assign mod_ent = {rd_id_q, mod_cnt};

  // forwarding at read: youngest in-flight match wins
  always_comb begin
    if (rd_vld_q && rd_addr_q == in_addr)      src_ent = mod_ent;
    else if (wb_vld_q && wb_addr_q == in_addr) src_ent = wb_ent_q;
    else                                       src_ent = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      wb_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= accept;
      wb_vld_q <= rd_vld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rd_id_q   <= in_id;
      rd_inc_q  <= in_inc;
      rd_addr_q <= in_addr;
      rd_ent_q  <= src_ent;
    end
    if (rd_vld_q) begin
      wb_addr_q <= rd_addr_q;
      wb_ent_q  <= mod_ent;
    end
  end

  assign busy    = rd_vld_q | wb_vld_q;
  assign wr_en   = wb_vld_q;
  assign wr_addr = wb_addr_q;
  assign wr_data = wb_ent_q;
endmodule

// File: rtl/hhd_scan.sv
module hhd_scan
  import hhd_pkg::*;
#(
  parameter int ID_W   = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  interval_end,
  input  logic                  busy,
  input  logic [ID_W+CNT_W-1:0] rd_data,
  input  logic [CNT_W-1:0]      threshold,
  output logic                  in_ready,
  output logic                  walking,
  output logic [ADDR_W-1:0]     walk_addr,
  output logic                  rep_valid,
  output logic [ID_W-1:0]       rep_id,
  output logic [CNT_W-1:0]      rep_count,
  output logic                  rep_done
);
  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              last_q, last_d;
  logic              done_q;
  logic              rv_q, rv_d;
  logic [ID_W-1:0]   rid_q;
  logic [CNT_W-1:0]  rcnt_q;
  logic              at_end;

  assign walking = (state_q == ST_INIT) || (state_q == ST_SCAN);
  assign at_end  = (addr_q == {ADDR_W{1'b1}});

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (interval_end) state_d = ST_DRAIN;
      ST_DRAIN: if (!busy)        state_d = ST_SCAN;
      default:  if (at_end)       state_d = ST_IDLE;
    endcase
    addr_d = walking ? addr_q + 1'b1 : '0;
    last_d = (state_q == ST_SCAN) && at_end;
    rv_d   = (state_q == ST_SCAN) && (rd_data[CNT_W-1:0] > threshold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      addr_q  <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      last_q  <= last_d;
      done_q  <= last_q;
      rv_q    <= rv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rv_d) begin
      rid_q  <= rd_data[CNT_W +: ID_W];
      rcnt_q <= rd_data[CNT_W-1:0];
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign walk_addr = addr_q;
  assign rep_valid = rv_q;
  assign rep_id    = rid_q;
  assign rep_count = rcnt_q;
  assign rep_done  = done_q;
endmodule

// File: rtl/hhd_flow_counter.sv
module hhd_flow_counter #(
  parameter int ID_W   = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_id,
  input  logic [CNT_W-1:0] in_inc,
  input  logic             interval_end,
  input  logic [CNT_W-1:0] threshold,
  output logic             rep_valid,
  output logic [ID_W-1:0]  rep_id,
  output logic [CNT_W-1:0] rep_count,
  output logic             rep_done
);
  localparam int ENT_W = ID_W + CNT_W;

  logic              rst_m_q, rst_s_q;
  logic              accept, busy, walking;
  logic [ADDR_W-1:0] hash_addr, walk_addr, rd_addr, t_wr_addr, u_wr_addr;
  logic [ENT_W-1:0]  rd_data, t_wr_data, u_wr_data;
  logic              t_wr_en, u_wr_en;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign accept = in_valid & in_ready;

  hhd_hash #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_hash (
    .id(in_id), .addr(hash_addr)
  );

  assign rd_addr   = walking ? walk_addr : hash_addr;
  assign t_wr_en   = walking | u_wr_en;
  assign t_wr_addr = walking ? walk_addr : u_wr_addr;
  assign t_wr_data = walking ? '0 : u_wr_data;

  hhd_table #(.ADDR_W(ADDR_W), .DATA_W(ENT_W)) u_table (
    .clk(clk), .wr_en(t_wr_en), .wr_addr(t_wr_addr), .wr_data(t_wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  hhd_update #(.ID_W(ID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_update (
    .clk(clk), .rst_n(rst_s_q), .accept(accept), .in_id(in_id),
    .in_inc(in_inc), .in_addr(hash_addr), .rd_data(rd_data), .busy(busy),
    .wr_en(u_wr_en), .wr_addr(u_wr_addr), .wr_data(u_wr_data)
  );

  hhd_scan #(.ID_W(ID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_scan (
    .clk(clk), .rst_n(rst_s_q), .interval_end(interval_end), .busy(busy),
    .rd_data(rd_data), .threshold(threshold), .in_ready(in_ready),
    .walking(walking), .walk_addr(walk_addr), .rep_valid(rep_valid),
    .rep_id(rep_id), .rep_count(rep_count), .rep_done(rep_done)
  );
endmodule

// File: rtl/hhd_flow_counter_chk.sv
module hhd_flow_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             interval_end,
  input logic [CNT_W-1:0] threshold,
  input logic             rep_valid,
  input logic [CNT_W-1:0] rep_count,
  input logic             rep_done
);
  AST_REP_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> rep_count > $past(threshold)); // R8

  AST_REP_ONLY_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> !$past(in_ready)); // R8

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && interval_end) |=> !in_ready); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_done |=> !rep_done); // R9

  AST_DONE_AFTER_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rep_done |-> (in_ready && !$past(in_ready, 2))); // R9
endmodule

bind hhd_flow_counter hhd_flow_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .interval_end(interval_end),
  .threshold(threshold), .rep_valid(rep_valid), .rep_count(rep_count),
  .rep_done(rep_done)
);

// File: tb/hhd_flow_counter_tb.sv
`timescale 1ns/1ps
module hhd_flow_counter_tb;
  logic        clk, rst_n, in_valid, in_ready, interval_end;
  logic [31:0] in_id, in_inc, threshold, rep_id, rep_count;
  logic        rep_valid, rep_done;

  hhd_flow_counter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_inc(in_inc), .interval_end(interval_end),
    .threshold(threshold), .rep_valid(rep_valid), .rep_id(rep_id),
    .rep_count(rep_count), .rep_done(rep_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mtag [1024];
  logic [31:0] mcnt [1024];
  logic [31:0] r_id [64];
  logic [31:0] r_cnt [64];
  int n_rep = 0, n_done = 0;

  // stimulus {id, increment}; expected results come from the model below
  localparam logic [63:0] VEC [14] = '{
    {32'h0000_0010, 32'd60},   {32'h0000_0010, 32'd50},
    {32'h0000_0020, 32'd100},  {32'h0000_0010, 32'd5},
    {32'h0000_0030, 32'd101},  {32'h0000_0040, 32'd1},
    {32'h0000_0010, 32'd1},    {32'h0000_0001, 32'd500},
    {32'h0000_0400, 32'd150},  {32'h0000_0055, 32'hFFFF_FF00},
    {32'h0000_0055, 32'h0000_0200}, {32'h0000_0066, 32'd200},
    {32'h0000_0066, 32'd200},  {32'h0000_0066, 32'd1}
  };

  function automatic logic [9:0] hfold(logic [31:0] v);
    return v[9:0] ^ v[19:10] ^ v[29:20] ^ {8'd0, v[31:30]};
  endfunction

  task automatic model_upd(logic [31:0] id, logic [31:0] inc);
    logic [9:0]  a = hfold(id);
    logic [32:0] s;
    if (mtag[a] == id) begin
      s = {1'b0, mcnt[a]} + {1'b0, inc};
      mcnt[a] = s[32] ? 32'hFFFF_FFFF : s[31:0];
    end else begin
      mtag[a] = id;
      mcnt[a] = inc;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) begin mtag[i] = '0; mcnt[i] = '0; end
  endtask

  task automatic check(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int find_rep(logic [31:0] id);
    for (int k = 0; k < n_rep; k++) if (r_id[k] == id) return k;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (rep_valid && n_rep < 64) begin
        r_id[n_rep]  = rep_id;
        r_cnt[n_rep] = rep_count;
        n_rep++;
      end
      if (rep_done) n_done++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic drive(logic [31:0] id, logic [31:0] inc, logic endp);
    @(negedge clk);
    in_valid = 1'b1; in_id = id; in_inc = inc; interval_end = endp;
    model_upd(id, inc);
  endtask

  task automatic wait_done(int start);
    int guard = 0;
    while (n_done == start && guard < 3000) begin @(negedge clk); guard++; end
  endtask

  task automatic compare_all(string req);
    int k = 0;
    for (int a = 0; a < 1024; a++) begin
      if (mcnt[a] > threshold) begin
        check(k < n_rep && r_id[k] == mtag[a], req, r_id[k], mtag[a]);
        check(k < n_rep && r_cnt[k] == mcnt[a], req, r_cnt[k], mcnt[a]);
        k++;
      end
    end
    check(n_rep == k, req, n_rep, k);
  endtask

  initial begin
    int idx, d0, guard;
    rst_n = 1'b0; in_valid = 1'b0; in_id = '0; in_inc = '0;
    interval_end = 1'b0; threshold = 32'd100;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state and clearing walk
    check(rep_valid == 1'b0 && rep_done == 1'b0, "R12", {rep_valid, rep_done}, 0);
    repeat (20) @(negedge clk);
    check(in_ready == 1'b0, "R12", in_ready, 0);
    guard = 0;
    while (!in_ready && guard < 2000) begin @(negedge clk); guard++; end
    check(in_ready == 1'b1, "R12", in_ready, 1);
    check(n_rep == 0 && n_done == 0, "R12", n_rep + n_done, 0);

    // interval 1: stimulus table, back-to-back
    foreach (VEC[i]) drive(VEC[i][63:32], VEC[i][31:0], 1'b0);
    @(negedge clk);
    in_valid = 1'b0; interval_end = 1'b1;
    @(negedge clk);
    interval_end = 1'b0;
    check(in_ready == 1'b0, "R7", in_ready, 0);
    d0 = n_done;
    repeat (30) @(negedge clk);
    interval_end = 1'b1;              // R11: pulse during walk
    @(negedge clk);
    interval_end = 1'b0;
    wait_done(d0);
    check(n_done == d0 + 1, "R9", n_done, d0 + 1);
    check(in_ready == 1'b1, "R9", in_ready, 1);
    compare_all("R8");
    check(n_rep > 0 && r_id[0] == 32'h400, "R1", r_id[0], 32'h400);
    idx = find_rep(32'h10);
    check(idx >= 0 && r_cnt[idx] == 32'd116, "R4", idx >= 0 ? r_cnt[idx] : 0, 116);
    idx = find_rep(32'h66);
    check(idx >= 0 && r_cnt[idx] == 32'd401, "R3", idx >= 0 ? r_cnt[idx] : 0, 401);
    idx = find_rep(32'h30);
    check(idx >= 0 && r_cnt[idx] == 32'd101, "R2", idx >= 0 ? r_cnt[idx] : 0, 101);
    idx = find_rep(32'h55);
    check(idx >= 0 && r_cnt[idx] == 32'hFFFF_FFFF, "R6", idx >= 0 ? r_cnt[idx] : 0, 32'hFFFF_FFFF);
    idx = find_rep(32'h400);
    check(idx >= 0 && r_cnt[idx] == 32'd150 && find_rep(32'h1) < 0, "R5",
          idx >= 0 ? r_cnt[idx] : 0, 150);
    check(find_rep(32'h20) < 0, "R8", find_rep(32'h20), 32'hFFFF_FFFF);

    // R11: ignored pulse starts no further walk
    n_rep = 0; d0 = n_done;
    repeat (1100) @(negedge clk);
    check(n_rep == 0 && n_done == d0, "R11", n_rep + n_done - d0, 0);
    check(in_ready == 1'b1, "R11", in_ready, 1);

    // interval 2: table cleared, update in pulse cycle counted
    model_clear();
    threshold = 32'd5;
    drive(32'h10, 32'd7, 1'b0);
    drive(32'h77, 32'd9, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; interval_end = 1'b0;
    check(in_ready == 1'b0, "R7", in_ready, 0);
    wait_done(d0);
    compare_all("R10");
    idx = find_rep(32'h10);
    check(idx >= 0 && r_cnt[idx] == 32'd7, "R10", idx >= 0 ? r_cnt[idx] : 0, 7);
    idx = find_rep(32'h77);
    check(idx >= 0 && r_cnt[idx] == 32'd9, "R7", idx >= 0 ? r_cnt[idx] : 0, 9);
    check(find_rep(32'h66) < 0, "R10", find_rep(32'h66), 32'hFFFF_FFFF);
    finish_run();
  end
endmodule